// File: doc/BRIEF.md
# Taxi Fare and Distance Calculator

This block meters one taxi trip. It counts wheel-sensor strobes to build up the distance travelled and works out the fare owed from that distance. It also adds a surcharge for time spent waiting. Distance is reported in binary hundredths of a kilometre and fare in binary tenths of a currency unit. A downstream BCD converter and display driver take both values as they are.

A trip runs while `start_i` is high. Dropping `start_i` or pulling `rst_ni` low clears all trip state, and the block then waits for the next trip.

The tariff has three parts:
- A fixed flag-fall charge covers the first few kilometres.
- After that, each completed kilometre adds a lower rate, and past a second distance threshold each kilometre adds a higher rate.
- While the vehicle is held (`pause_i` high) after the flag-fall zone has been passed, once-per-second ticks are counted. Every full waiting period adds a small fixed amount.

Both distance and fare saturate at the top of their display range.

Top module: `taxi_fare_core`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released with `start_i` low, `dist_o` and `fare_o` are both 0.
- R2: One cycle after `start_i` is sampled low, `dist_o` and `fare_o` read 0. One cycle after `start_i` is sampled high at the start of a new trip, `fare_o` reads the flag-fall value 90 (9.0).
- R3: A distance strobe sampled with `start_i` high and `pause_i` low adds 2 (20 m) to `dist_o` one cycle later.
- R4: While `dist_o` is at most 300 (3.00 km), `fare_o` stays at 90.
- R5: Every 50th accepted strobe completes a kilometre. Completing kilometres 4 through 9 adds 20 (2.0) each to `fare_o`, in the same cycle that `dist_o` reaches the kilometre mark.
- R6: Completing kilometre 10 and every later kilometre adds 30 (3.0) each to `fare_o`.
- R7: Distance strobes sampled while `pause_i` is high leave `dist_o` unchanged.
- R8: With `start_i` and `pause_i` high and `dist_o` above 300, every `WAIT_TICKS`-th second tick adds 5 (0.5) to `fare_o` (default 180 ticks, 3 minutes). Ticks sampled while `dist_o` is 300 or less add nothing.
- R9: The partial waiting-tick count is kept when `pause_i` drops and resumes when it returns.
- R10: Distance strobes sampled while `start_i` is low are ignored.
- R11: `dist_o` never exceeds 9999 (99.99 km). Once there, further strobes are ignored.
- R12: `fare_o` never exceeds 9999 (999.9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Trip active; low clears the trip |
| pause_i | input | 1 | Vehicle held; enables the waiting surcharge, blocks distance |
| dist_pulse_i | input | 1 | Single-cycle strobe per 20 m of travel |
| sec_tick_i | input | 1 | Single-cycle strobe once per second |
| dist_o | output | 14 | Distance in 0.01 km units |
| fare_o | output | 14 | Fare in 0.1 currency units |

## Verification
The bench steps across the tier edges one strobe at a time: strobe 151 must still read 90, strobe 200 must read 110, and the tenth kilometre must add 30 rather than 20. A design with an off-by-one threshold shows the rate change one kilometre early or late.

During a pause it interleaves a partial tick count with a short drive. A design that clears the tick counter on resume charges one waiting period too few. It also waits inside the flag-fall zone, where any surcharge is wrong.

It drives distance to saturation, where an unguarded adder wraps to a small value. It then pushes the waiting charge past the fare ceiling, where a narrow sum would wrap.

// File: rtl/taxi_fare_pkg.sv
package taxi_fare_pkg;

  // Per-kilometre charge for the kilometre that ends at mark km_done.
  function automatic int unsigned km_rate(input int unsigned km_done,
                                          input int unsigned tier1_km,
                                          input int unsigned tier2_km,
                                          input int unsigned rate1,
                                          input int unsigned rate2);
    if (km_done > tier2_km)      return rate2;
    else if (km_done > tier1_km) return rate1;
    else                         return 0;
  endfunction

  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned cap);
    int unsigned s;
    s = a + b;
    return (s > cap) ? cap : s;
  endfunction

endpackage

// File: rtl/taxi_dist_acc.sv
module taxi_dist_acc
  import taxi_fare_pkg::*;
#(
  parameter int unsigned DIST_W        = 14,
  parameter int unsigned FARE_W        = 14,
  parameter int unsigned PULSES_PER_KM = 50,
  parameter int unsigned STEP          = 2,
  parameter int unsigned DIST_MAX      = 9999,
  parameter int unsigned FARE_MAX      = 9999,
  parameter int unsigned TIER1_KM      = 3,
  parameter int unsigned TIER2_KM      = 9,
  parameter int unsigned RATE1         = 20,
  parameter int unsigned RATE2         = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              accept_i,
  output logic [DIST_W-1:0] dist_o,
  output logic [FARE_W-1:0] chg_o,
  output logic              past_tier1_o
);
  localparam int unsigned PC_W     = $clog2(PULSES_PER_KM);
  localparam int unsigned KM_MAX   = DIST_MAX / (PULSES_PER_KM * STEP) + 2;
  localparam int unsigned KM_W     = $clog2(KM_MAX);
  localparam int unsigned T1_DIST  = TIER1_KM * PULSES_PER_KM * STEP;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSES_PER_KM - 1);

  logic [DIST_W-1:0] dist_q;
  logic [FARE_W-1:0] chg_q;
  logic [PC_W-1:0]   pc_q;
  logic [KM_W-1:0]   km_q;
  logic              take;
  logic [KM_W-1:0]   km_next;

  assign take    = accept_i && (32'(dist_q) != DIST_MAX);
  assign km_next = km_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_q <= '0;
      chg_q  <= '0;
      pc_q   <= '0;
      km_q   <= '0;
    end else if (clr_i) begin
      dist_q <= '0;
      chg_q  <= '0;
      pc_q   <= '0;
      km_q   <= '0;
    end else if (take) begin
      dist_q <= DIST_W'(sat_add(32'(dist_q), STEP, DIST_MAX));
      if (pc_q == PC_LAST) begin
        pc_q  <= '0;
        km_q  <= km_next;
        chg_q <= FARE_W'(sat_add(32'(chg_q),
                   km_rate(32'(km_next), TIER1_KM, TIER2_KM, RATE1, RATE2),
                   FARE_MAX));
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign dist_o       = dist_q;
  assign chg_o        = chg_q;
  assign past_tier1_o = 32'(dist_q) > T1_DIST;
endmodule

// File: rtl/taxi_wait_acc.sv
module taxi_wait_acc
  import taxi_fare_pkg::*;
#(
  parameter int unsigned FARE_W     = 14,
  parameter int unsigned FARE_MAX   = 9999,
  parameter int unsigned WAIT_TICKS = 180,
  parameter int unsigned WAIT_STEP  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              count_i,
  output logic [FARE_W-1:0] chg_o
);
  localparam int unsigned TC_W = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(WAIT_TICKS - 1);

  logic [TC_W-1:0]   tc_q;
  logic [FARE_W-1:0] chg_q;

  // Partial tick count is kept while not counting.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q  <= '0;
      chg_q <= '0;
    end else if (clr_i) begin
      tc_q  <= '0;
      chg_q <= '0;
    end else if (count_i) begin
      if (tc_q == TC_LAST) begin
        tc_q  <= '0;
        chg_q <= FARE_W'(sat_add(32'(chg_q), WAIT_STEP, FARE_MAX));
      end else begin
        tc_q <= tc_q + 1'b1;
      end
    end
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/taxi_fare_core.sv
module taxi_fare_core
  import taxi_fare_pkg::*;
#(
  parameter int unsigned DIST_W        = 14,
  parameter int unsigned FARE_W        = 14,
  parameter int unsigned PULSES_PER_KM = 50,
  parameter int unsigned STEP          = 2,
  parameter int unsigned DIST_MAX      = 9999,
  parameter int unsigned FARE_MAX      = 9999,
  parameter int unsigned FLAG_FALL     = 90,
  parameter int unsigned TIER1_KM      = 3,
  parameter int unsigned TIER2_KM      = 9,
  parameter int unsigned RATE1         = 20,
  parameter int unsigned RATE2         = 30,
  parameter int unsigned WAIT_TICKS    = 180,
  parameter int unsigned WAIT_STEP     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pause_i,
  input  logic              dist_pulse_i,
  input  logic              sec_tick_i,
  output logic [DIST_W-1:0] dist_o,
  output logic [FARE_W-1:0] fare_o
);
  localparam int unsigned SUM_W = FARE_W + 2;

  logic              run_q;
  logic              clr;
  logic              accept;
  logic              wait_cnt;
  logic              past_tier1;
  logic [FARE_W-1:0] dist_chg;
  logic [FARE_W-1:0] wait_chg;
  logic [SUM_W-1:0]  sum;

  assign clr      = !start_i;
  assign accept   = start_i && !pause_i && dist_pulse_i;
  assign wait_cnt = start_i && pause_i && sec_tick_i && past_tier1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= start_i;
  end

  taxi_dist_acc #(
    .DIST_W(DIST_W), .FARE_W(FARE_W), .PULSES_PER_KM(PULSES_PER_KM),
    .STEP(STEP), .DIST_MAX(DIST_MAX), .FARE_MAX(FARE_MAX),
    .TIER1_KM(TIER1_KM), .TIER2_KM(TIER2_KM), .RATE1(RATE1), .RATE2(RATE2)
  ) u_dist (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .accept_i(accept),
    .dist_o(dist_o), .chg_o(dist_chg), .past_tier1_o(past_tier1)
  );

  taxi_wait_acc #(
    .FARE_W(FARE_W), .FARE_MAX(FARE_MAX),
    .WAIT_TICKS(WAIT_TICKS), .WAIT_STEP(WAIT_STEP)
  ) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .count_i(wait_cnt),
    .chg_o(wait_chg)
  );

  assign sum = SUM_W'(FLAG_FALL) + SUM_W'(dist_chg) + SUM_W'(wait_chg);

  always_comb begin
    if (!run_q)                      fare_o = '0;
    else if (32'(sum) > FARE_MAX)    fare_o = FARE_W'(FARE_MAX);
    else                             fare_o = sum[FARE_W-1:0];
  end
endmodule

// File: rtl/taxi_fare_core_chk.sv
module taxi_fare_core_chk #(
  parameter int unsigned DIST_W        = 14,
  parameter int unsigned FARE_W        = 14,
  parameter int unsigned PULSES_PER_KM = 50,
  parameter int unsigned STEP          = 2,
  parameter int unsigned DIST_MAX      = 9999,
  parameter int unsigned FARE_MAX      = 9999,
  parameter int unsigned FLAG_FALL     = 90,
  parameter int unsigned TIER1_KM      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              pause_i,
  input logic              dist_pulse_i,
  input logic [DIST_W-1:0] dist_o,
  input logic [FARE_W-1:0] fare_o
);
  localparam int unsigned T1_DIST = TIER1_KM * PULSES_PER_KM * STEP;

  p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> (dist_o == '0 && fare_o == '0));

  p_dist_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pause_i && dist_pulse_i && 32'(dist_o) + STEP <= DIST_MAX)
    |=> 32'(dist_o) == 32'($past(dist_o)) + STEP);

  p_flag_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i) && 32'(dist_o) <= T1_DIST) |-> 32'(fare_o) == FLAG_FALL);

  p_pause_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && pause_i) |=> $stable(dist_o));

  p_dist_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(dist_o) <= DIST_MAX);

  p_fare_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fare_o) <= FARE_MAX);
endmodule

bind taxi_fare_core taxi_fare_core_chk #(
  .DIST_W(DIST_W), .FARE_W(FARE_W), .PULSES_PER_KM(PULSES_PER_KM),
  .STEP(STEP), .DIST_MAX(DIST_MAX), .FARE_MAX(FARE_MAX),
  .FLAG_FALL(FLAG_FALL), .TIER1_KM(TIER1_KM)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pause_i(pause_i),
  .dist_pulse_i(dist_pulse_i), .dist_o(dist_o), .fare_o(fare_o)
);

// File: tb/taxi_fare_core_tb_top.sv
module taxi_fare_core_tb_top;
  localparam int WT = 6;  // shortened waiting period for the bench

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        pause_i = 1'b0;
  logic        dist_pulse_i = 1'b0;
  logic        sec_tick_i = 1'b0;
  logic [13:0] dist_o;
  logic [13:0] fare_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2ns clk_i = ~clk_i;

  taxi_fare_core #(.WAIT_TICKS(WT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pause_i(pause_i),
    .dist_pulse_i(dist_pulse_i), .sec_tick_i(sec_tick_i),
    .dist_o(dist_o), .fare_o(fare_o)
  );

  // Drive-through table: strobes to add, then expected distance and fare.
  localparam int NV = 8;
  localparam int V_PULSES[NV] = '{1,  49,  100, 1,   49,  250, 50,   50};
  localparam int V_DIST[NV]   = '{2,  100, 300, 302, 400, 900, 1000, 1100};
  localparam int V_FARE[NV]   = '{90, 90,  90,  90,  110, 210, 240,  270};

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) dist_pulse_i = 1'b1;
      @(negedge clk_i) dist_pulse_i = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) sec_tick_i = 1'b1;
      @(negedge clk_i) sec_tick_i = 1'b0;
    end
  endtask

  task automatic new_trip();
    @(negedge clk_i) start_i = 1'b0; pause_i = 1'b0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 dist in reset", int'(dist_o), 0);
    check("R1 fare in reset", int'(fare_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 dist after release", int'(dist_o), 0);
    check("R1 fare after release", int'(fare_o), 0);

    // R10: strobes while idle are ignored
    pulses(5);
    check("R10 dist idle strobes", int'(dist_o), 0);

    new_trip();
    check("R2 flag fall at trip start", int'(fare_o), 90);
    check("R2 dist at trip start", int'(dist_o), 0);

    // R3 R4 R5 R6 via table
    for (int v = 0; v < NV; v++) begin
      pulses(V_PULSES[v]);
      check($sformatf("R3 table dist row %0d", v), int'(dist_o), V_DIST[v]);
      check($sformatf("R5 R6 table fare row %0d", v), int'(fare_o), V_FARE[v]);
    end

    // R7: strobes during pause ignored
    @(negedge clk_i) pause_i = 1'b1;
    pulses(5);
    check("R7 dist held during pause", int'(dist_o), 1100);

    // R8: one full waiting period
    ticks(WT);
    check("R8 waiting surcharge", int'(fare_o), 275);

    // R9: partial count survives a resume
    ticks(WT - 2);
    @(negedge clk_i) pause_i = 1'b0;
    pulses(1);
    check("R9 dist after resume", int'(dist_o), 1102);
    @(negedge clk_i) pause_i = 1'b1;
    ticks(1);
    check("R9 fare before period ends", int'(fare_o), 275);
    ticks(1);
    check("R9 fare after resumed count", int'(fare_o), 280);

    // R2: start low clears
    @(negedge clk_i) start_i = 1'b0; pause_i = 1'b0;
    @(negedge clk_i);
    check("R2 dist cleared", int'(dist_o), 0);
    check("R2 fare cleared", int'(fare_o), 0);

    // R8: waiting inside flag-fall zone earns nothing
    new_trip();
    pulses(150);
    @(negedge clk_i) pause_i = 1'b1;
    ticks(2 * WT);
    check("R8 no surcharge at 3.00 km", int'(fare_o), 90);
    check("R4 dist at 3.00 km", int'(dist_o), 300);

    // R11: distance saturation
    new_trip();
    pulses(5000);
    check("R11 dist at ceiling", int'(dist_o), 9999);
    check("R6 fare at 100 km", int'(fare_o), 2940);
    pulses(3);
    check("R11 dist stays at ceiling", int'(dist_o), 9999);
    check("R11 fare unchanged past ceiling", int'(fare_o), 2940);

    // R12: fare saturation through waiting charge
    @(negedge clk_i) pause_i = 1'b1;
    ticks(1412 * WT - WT);
    check("R12 fare just below ceiling", int'(fare_o), 9995);
    ticks(WT);
    check("R12 fare at ceiling", int'(fare_o), 9999);
    ticks(3 * WT);
    check("R12 fare stays at ceiling", int'(fare_o), 9999);

    // R1: asynchronous reset mid-trip
    #1ns rst_ni = 1'b0;
    #1ns;
    check("R1 dist async clear", int'(dist_o), 0);
    check("R1 fare async clear", int'(fare_o), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule